// File: doc/BRIEF.md
# Auto-Increment Packet Data Port

This block is the host's window into packet buffer memory. The host first writes a pointer word. That word chooses the receive area or the transmit area, gives a byte offset, and carries two flags: one makes the offset advance by itself, the other marks the transfer as a read. The host then reads or writes bytes through a data register, using 8-, 16- or 32-bit accesses. The offset can step forward after each access, so a whole packet streams through one address.

Each area holds 2 KB of byte-addressed memory. Memory is little-endian, and an access may start at any byte offset. A packet starts with a 16-bit status word and then a 16-bit byte count. A 32-bit read at the start of a packet therefore returns both at once, with the status in the low half. A driver can reread only the count by pointing two bytes into the packet. Register offset 6 selects the pointer and offset 8 selects the data register. Read responses arrive one cycle after the request.

Top module: `pkt_data_port`

## Requirements
- R1: After synchronous reset, rsp_valid is 0 and the pointer reads back as 0x0000.
- R2: A write to register offset 6 loads the pointer from req_wdata[15:0]. Bit 15 selects the receive area (1) or the transmit area (0). Bit 14 enables auto-increment. Bit 13 marks a read. Bits 10:0 are the byte offset. Bits 12:11 read back as 0.
- R3: A data write (offset 8) stores 1, 2 or 4 bytes for req_size 0, 1 or 2. The byte from req_wdata[7:0] goes to the pointer offset, and each following byte goes to the next higher offset. Any starting alignment is allowed.
- R4: A read of offset 6 or 8 raises rsp_valid exactly one cycle later. Read data is little-endian, and bytes beyond the access size are zero.
- R5: With bit 14 set, each data access advances the offset by its size in bytes (1, 2 or 4).
- R6: With bit 14 clear, data accesses leave the pointer unchanged, so repeated reads return the same bytes.
- R7: Offsets wrap within the 2 KB area. A 4-byte access at offset 2046 touches 2046, 2047, 0 and 1, and leaves the offset at 2.
- R8: The receive area and the transmit area are separate, so the same offset in each holds independent data.
- R9: A data write while pointer bit 13 is set has no effect. Memory is unchanged and the pointer does not advance.
- R10: For a packet with status S at offset 0 and byte count N at offset 2, a 32-bit read from offset 0 returns {N, S}. Pointer value 0xE002 followed by a 16-bit read returns N.
- R11: Requests to any register offset other than 6 or 8 produce no response and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access in this cycle |
| req_addr | input | 4 | Register offset (6 pointer, 8 data) |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data, lowest offset on bits 7:0 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended |

## Verification
The hardest case to reach from the ports is an access that crosses the end of an area, where the bytes and the offset must both wrap. Close behind it is an unaligned word whose bytes land in rotated lanes. The stimulus reaches these states directly by loading the pointer with offsets 2046 and 2047. It also reads at odd offsets after a mixed run of byte, halfword and word writes. To prove that ignored writes had no effect, the bench reads back both the pointer and the memory behind it.

// File: rtl/pkt_port_pkg.sv
package pkt_port_pkg;

    localparam int PTR_OFF_W = 11;
    localparam int BUS_BYTES = 4;
    localparam logic [3:0] REG_PTR  = 4'h6;
    localparam logic [3:0] REG_DATA = 4'h8;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_WIDE = 2'd3
    } acc_size_e;

    // Pointer word: area, auto-advance, read flag, reserved, offset
    typedef struct packed {
        logic                 rcv;
        logic                 autoinc;
        logic                 rd;
        logic [1:0]           rsvd;
        logic [PTR_OFF_W-1:0] off;
    } ptr_t;

    function automatic logic [2:0] size_bytes(input logic [1:0] s);
        case (s)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pkt_ptr_reg.sv
module pkt_ptr_reg
    import pkt_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ptr_we,
    input  logic [15:0] ptr_wdata,
    input  logic        adv,
    input  logic [2:0]  adv_bytes,
    output ptr_t        ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_we) begin
            ptr.rcv     <= ptr_wdata[15];
            ptr.autoinc <= ptr_wdata[14];
            ptr.rd      <= ptr_wdata[13];
            ptr.rsvd    <= 2'b00;
            ptr.off     <= ptr_wdata[PTR_OFF_W-1:0];
        end else if (adv && ptr.autoinc) begin
            ptr.off <= ptr.off + PTR_OFF_W'(adv_bytes);
        end
    end

    // R5: offset steps by access size, modulo area size
    assert_autoinc_step_R5: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr.autoinc && !ptr_we) |=>
            (ptr.off == PTR_OFF_W'($past(ptr.off) + PTR_OFF_W'($past(adv_bytes)))));

    // R6: no auto-increment means the pointer holds
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && !ptr.autoinc && !ptr_we) |=> $stable(ptr));

endmodule

// File: rtl/pkt_lane_mem.sv
module pkt_lane_mem #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pkt_lane_steer.sv
module pkt_lane_steer
    import pkt_port_pkg::*;
#(
    parameter int OFF_W = PTR_OFF_W,
    parameter int LANES = BUS_BYTES
) (
    input  logic [OFF_W-1:0]             off,
    input  logic [2:0]                   nbytes,
    input  logic [LANES*8-1:0]           wdata,
    input  logic [LANES-1:0][7:0]        lane_rdata,
    output logic [LANES-1:0][OFF_W-3:0]  lane_row,
    output logic [LANES-1:0]             lane_en,
    output logic [LANES-1:0][7:0]        lane_wdata,
    output logic [LANES*8-1:0]           rdata
);

    // Per memory lane: which bus byte maps here and which row it hits
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic [1:0]       idx;
        logic [OFF_W-1:0] a;
        always_comb begin
            idx = 2'(L) - off[1:0];
            a   = off + OFF_W'(idx);
        end
        assign lane_row[L]   = a[OFF_W-1:2];
        assign lane_en[L]    = ({1'b0, idx} < nbytes);
        assign lane_wdata[L] = wdata[idx*8 +: 8];
    end

    // Per bus byte: pick the lane holding it, zero beyond the size
    for (genvar i = 0; i < LANES; i++) begin : g_byte
        logic [1:0] sel;
        assign sel = 2'(i) + off[1:0];
        assign rdata[i*8 +: 8] = (3'(i) < nbytes) ? lane_rdata[sel] : 8'h00;
    end

endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
    import pkt_port_pkg::*;
#(
    parameter int OFF_W = PTR_OFF_W,
    parameter int LANES = BUS_BYTES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_addr,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);

    localparam int ROW_W = OFF_W - 2;
    localparam int MEM_AW = ROW_W + 1;

    ptr_t                        ptr;
    logic                        is_ptr;
    logic                        is_data;
    logic                        ptr_we;
    logic                        data_wr;
    logic                        adv;
    logic [2:0]                  nbytes;
    logic [LANES-1:0][ROW_W-1:0] lane_row;
    logic [LANES-1:0]            lane_en;
    logic [LANES-1:0][7:0]       lane_wdata;
    logic [LANES-1:0][7:0]       lane_rdata;
    logic [LANES*8-1:0]          steer_rdata;

    always_comb begin
        is_ptr  = req_valid && (req_addr == REG_PTR);
        is_data = req_valid && (req_addr == REG_DATA);
        nbytes  = size_bytes(req_size);
        ptr_we  = is_ptr && req_write;
        data_wr = is_data && req_write && !ptr.rd;
        adv     = is_data && (!req_write || !ptr.rd);
    end

    pkt_ptr_reg u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ptr_we    (ptr_we),
        .ptr_wdata (req_wdata[15:0]),
        .adv       (adv),
        .adv_bytes (nbytes),
        .ptr       (ptr)
    );

    pkt_lane_steer #(.OFF_W(OFF_W), .LANES(LANES)) u_steer (
        .off        (ptr.off),
        .nbytes     (nbytes),
        .wdata      (req_wdata),
        .lane_rdata (lane_rdata),
        .lane_row   (lane_row),
        .lane_en    (lane_en),
        .lane_wdata (lane_wdata),
        .rdata      (steer_rdata)
    );

    for (genvar L = 0; L < LANES; L++) begin : g_mem
        pkt_lane_mem #(.AW(MEM_AW)) u_lane (
            .clk   (clk),
            .we    (data_wr && lane_en[L]),
            .addr  ({ptr.rcv, lane_row[L]}),
            .wdata (lane_wdata[L]),
            .rdata (lane_rdata[L])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (is_ptr || is_data) && !req_write;
            if (is_ptr && !req_write) begin
                rsp_rdata <= {16'h0000, ptr};
            end else if (is_data && !req_write) begin
                rsp_rdata <= steer_rdata;
            end
        end
    end

    // R3: an accepted write enables exactly as many lanes as bytes
    assert_lane_count_R3: assert property (@(posedge clk) disable iff (rst)
        data_wr |-> ($countones(lane_en) == 32'(nbytes)));

    // R4: a read answers on the next cycle
    assert_rsp_follows_R4: assert property (@(posedge clk) disable iff (rst)
        ((is_ptr || is_data) && !req_write) |=> rsp_valid);

    // R11: nothing answers a write or an unknown offset
    assert_no_stray_rsp_R11: assert property (@(posedge clk) disable iff (rst)
        !((is_ptr || is_data) && !req_write) |=> !rsp_valid);

    // R4: a byte read leaves the upper bytes zero
    assert_byte_zext_R4: assert property (@(posedge clk) disable iff (rst)
        (is_data && !req_write && req_size == ACC_BYTE) |=> (rsp_rdata[31:8] == 24'h0));

    // R9: a blocked data write leaves the pointer alone
    assert_blocked_write_R9: assert property (@(posedge clk) disable iff (rst)
        (is_data && req_write && ptr.rd) |=> $stable(ptr));

endmodule

// File: tb/tb_pkt_data_port.sv
module tb_pkt_data_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pkt_data_port dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    typedef struct packed {
        logic [3:0]  addr;
        logic        wr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'h6, 1'b1, 2'd1, 32'h0000_4000, 1'b0, 32'h0,          4'd5},  // tx, auto, offset 0
        '{4'h8, 1'b1, 2'd2, 32'h4433_2211, 1'b0, 32'h0,          4'd3},  // R3 word
        '{4'h8, 1'b1, 2'd1, 32'h0000_6655, 1'b0, 32'h0,          4'd3},  // R3 half
        '{4'h8, 1'b1, 2'd0, 32'h0000_0077, 1'b0, 32'h0,          4'd3},  // R3 byte
        '{4'h6, 1'b0, 2'd1, 32'h0,         1'b1, 32'h0000_4007,  4'd5},  // R5 4+2+1
        '{4'h6, 1'b1, 2'd1, 32'h0000_6000, 1'b0, 32'h0,          4'd2},  // tx, auto, read
        '{4'h8, 1'b0, 2'd0, 32'h0,         1'b1, 32'h0000_0011,  4'd4},  // R4 byte
        '{4'h8, 1'b0, 2'd2, 32'h0,         1'b1, 32'h5544_3322,  4'd3},  // R3 unaligned word
        '{4'h8, 1'b0, 2'd1, 32'h0,         1'b1, 32'h0000_7766,  4'd4},  // R4 half
        '{4'h6, 1'b0, 2'd1, 32'h0,         1'b1, 32'h0000_6007,  4'd5},  // R5 1+4+2
        '{4'h6, 1'b1, 2'd1, 32'h0000_C000, 1'b0, 32'h0,          4'd8},  // rx, auto, write
        '{4'h8, 1'b1, 2'd1, 32'h0000_2001, 1'b0, 32'h0,          4'd10}, // status
        '{4'h8, 1'b1, 2'd1, 32'h0000_0040, 1'b0, 32'h0,          4'd10}, // length 64
        '{4'h6, 1'b1, 2'd1, 32'h0000_E000, 1'b0, 32'h0,          4'd10},
        '{4'h8, 1'b0, 2'd2, 32'h0,         1'b1, 32'h0040_2001,  4'd10}, // R10 header word
        '{4'h6, 1'b1, 2'd1, 32'h0000_E002, 1'b0, 32'h0,          4'd10},
        '{4'h8, 1'b0, 2'd1, 32'h0,         1'b1, 32'h0000_0040,  4'd10}, // R10 restart at 2
        '{4'h6, 1'b1, 2'd1, 32'h0000_2000, 1'b0, 32'h0,          4'd8},  // tx, no auto
        '{4'h8, 1'b0, 2'd2, 32'h0,         1'b1, 32'h4433_2211,  4'd8},  // R8 tx intact
        '{4'h8, 1'b0, 2'd2, 32'h0,         1'b1, 32'h4433_2211,  4'd6},  // R6 same bytes
        '{4'h6, 1'b0, 2'd1, 32'h0,         1'b1, 32'h0000_2000,  4'd6},  // R6 pointer held
        '{4'h6, 1'b1, 2'd2, 32'hABCD_FFFF, 1'b0, 32'h0,          4'd2},
        '{4'h6, 1'b0, 2'd1, 32'h0,         1'b1, 32'h0000_E7FF,  4'd2}   // R2 reserved zero
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int rq, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic op(input logic [3:0] a, input logic w, input logic [1:0] s,
                      input logic [31:0] d, output logic v, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_size  = s;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        v = rsp_valid;
        r = rsp_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        logic v;
        logic [31:0] r;
        op(a, 1'b1, s, d, v, r);
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [1:0] s, input logic [31:0] exp,
                            input int rq, input string what);
        logic v;
        logic [31:0] r;
        op(a, 1'b0, s, 32'h0, v, r);
        check({31'h0, v}, 32'h1, rq, {what, " valid"});
        check(r, exp, rq, what);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic v;
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check({31'h0, rsp_valid}, 32'h0, 1, "rsp_valid after reset");
        rd_check(4'h6, 2'd1, 32'h0, 1, "pointer after reset");

        for (int i = 0; i < NV; i++) begin
            op(VECS[i].addr, VECS[i].wr, VECS[i].size, VECS[i].wdata, v, r);
            if (VECS[i].chk) begin
                check({31'h0, v}, 32'h1, int'(VECS[i].req), $sformatf("vector %0d valid", i));
                check(r, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d data", i));
            end
        end

        // R7: word write across the end of the transmit area
        wr(4'h6, 2'd1, 32'h0000_47FE);
        wr(4'h8, 2'd2, 32'hDDCC_BBAA);
        rd_check(4'h6, 2'd1, 32'h0000_4002, 7, "offset wrapped to 2");
        wr(4'h6, 2'd1, 32'h0000_67FF);
        rd_check(4'h8, 2'd1, 32'h0000_CCBB, 7, "half read 2047..0");
        wr(4'h6, 2'd1, 32'h0000_6001);
        rd_check(4'h8, 2'd0, 32'h0000_00DD, 7, "byte 1 after wrap");

        // R9: write while read flag set is dropped
        wr(4'h6, 2'd1, 32'h0000_E000);
        wr(4'h8, 2'd2, 32'hFFFF_FFFF);
        rd_check(4'h6, 2'd1, 32'h0000_E000, 9, "pointer not advanced");
        rd_check(4'h8, 2'd2, 32'h0040_2001, 9, "memory unchanged");

        // R11: other register offsets are inert
        op(4'h0, 1'b0, 2'd1, 32'h0, v, r);
        check({31'h0, v}, 32'h0, 11, "no response at offset 0");
        wr(4'h4, 2'd1, 32'h0000_1234);
        rd_check(4'h6, 2'd1, 32'h0000_E004, 11, "pointer untouched by offset 4");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule